// File: doc/BRIEF.md
# RTC Rate Divider with Square-Wave and Periodic Interrupt

This block turns a 32.768 kHz clock-enable tick, running on a faster system clock, into a binary divider chain. A three-bit oscillator control field decides whether the chain counts, is held at zero, or is stopped. A four-bit rate code picks one stage of the chain. That stage drives a square-wave pin and also sets a periodic-event flag once per period. The square wave and the periodic interrupt have separate enables. A raw-rate override puts the base tick straight onto the square-wave pin.

The periodic flag and a set of external event flags each have an enable bit. Together they form one summary flag and one active-low interrupt line. A single clear strobe, which stands for a status read, wipes every flag. All configuration fields are loaded together by one write strobe.

Top module: `rtc_rate_unit`

## Requirements
- R1: With the oscillator code cfg_osc[2:1] = 2'b01, the divider counts one step per tick, and cfg_osc[0] has no effect (010 and 011 behave the same).
- R2: With cfg_osc[2:1] = 2'b11 the divider is held at zero. With 2'b00 or 2'b10 the oscillator is stopped. In both cases the periodic flag is never set and sqw stays low, even with the raw override on. When counting resumes, the chain starts again from zero.
- R3: The rate code selects divider stage k. The mapping is 0001→6, 0010→7, 0011→1, 0100→2, and codes 0101..1111→code−2 (stages 3..13). After counting starts, the periodic flag (flags[0]) is first set on tick 2^(k+1), and it repeats at that period.
- R4: With cfg_sq_en = 1 and cfg_raw_en = 0, sqw is a square wave at the selected stage. It first rises on tick 2^k after counting starts.
- R5: With cfg_raw_en = 1 and the chain running, sqw equals tick_32k, whatever cfg_sq_en and cfg_rate are.
- R6: With cfg_sq_en = 0 and cfg_raw_en = 0, sqw stays low.
- R7: The periodic flag is set whether or not cfg_pi_en is set. Only cfg_pi_en lets it reach the interrupt.
- R8: irq_any is 1 exactly when some flag has its enable set. flags[0] is paired with cfg_pi_en, and flags[i+1] with cfg_src_en[i]. irq_n is the inverse of irq_any.
- R9: flag_clr clears every flag. A set request in the same cycle wins over the clear for that flag.
- R10: Rate code 0000 produces no periodic flag, and sqw stays low when the override is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz base rate |
| cfg_we | input | 1 | Loads all cfg_* fields |
| cfg_osc | input | 3 | Oscillator/divider control code |
| cfg_rate | input | 4 | Rate select code |
| cfg_sq_en | input | 1 | Square-wave enable |
| cfg_raw_en | input | 1 | Raw base-rate override on sqw |
| cfg_pi_en | input | 1 | Periodic interrupt enable |
| cfg_src_en | input | NUM_EXT | Enables for external flags |
| src_set | input | NUM_EXT | Set requests for external flags |
| flag_clr | input | 1 | Clears all flags (status read) |
| sqw | output | 1 | Square-wave output |
| irq_n | output | 1 | Active-low interrupt line |
| irq_any | output | 1 | Summary interrupt flag |
| flags | output | NUM_EXT+1 | Flag bits; bit 0 is the periodic flag |

## Verification
The main stimulus sweeps every non-zero rate code from a fresh chain restart. For each code the bench measures the tick count to the first square-wave rise and to the first periodic flag. This separates a wrong stage choice from an off-by-one in the wrap detection. Odd and even codes alternate the ignored oscillator bit, so a decode that depends on it shows up as a missing flag. Separate patterns cover each stopped and held oscillator code with the override on, the override with square-wave disabled and rate zero, and flag and enable combinations with and without a coincident clear. Together these tell gating errors apart from priority errors.

// File: rtl/rtc_rate_pkg.sv
package rtc_rate_pkg;

   typedef enum logic [1:0] {
      OSC_STOP = 2'd0,
      OSC_HOLD = 2'd1,
      OSC_RUN  = 2'd2
   } osc_mode_e;

   // Bits [2:1] decide the mode; bit 0 is don't-care (R1, R2)
   function automatic osc_mode_e osc_decode(input logic [2:0] code);
      case (code[2:1])
         2'b01:   return OSC_RUN;
         2'b11:   return OSC_HOLD;
         default: return OSC_STOP;
      endcase
   endfunction

   // Rate code to divider stage index (R3)
   function automatic logic [3:0] rate_stage(input logic [3:0] code);
      case (code)
         4'd0:    return 4'd0;
         4'd1:    return 4'd6;
         4'd2:    return 4'd7;
         4'd3:    return 4'd1;
         4'd4:    return 4'd2;
         default: return code - 4'd2;
      endcase
   endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider
   import rtc_rate_pkg::*;
#(
   parameter int DIV_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  osc_mode_e        mode,
   output logic [DIV_W-1:0] cnt,
   output logic             run
);

   assign run = (mode == OSC_RUN);

   // Held or stopped clears the chain so a restart begins from zero (R2)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (tick)   cnt <= cnt + DIV_W'(1);
   end

endmodule

// File: rtl/rtc_tap_sel.sv
module rtc_tap_sel
   import rtc_rate_pkg::*;
#(
   parameter int DIV_W = 14
) (
   input  logic [DIV_W-1:0] cnt,
   input  logic             tick,
   input  logic             run,
   input  logic [3:0]       rate,
   output logic             tap_lvl,
   output logic             pf_pulse
);

   localparam int IDX_W = $clog2(DIV_W);

   logic [DIV_W-1:0] wrap;
   logic [IDX_W-1:0] idx;
   logic             active;

   // wrap[k]: stage k is about to complete a full period on the next tick
   for (genvar k = 0; k < DIV_W; k++) begin : g_wrap
      assign wrap[k] = &cnt[k:0];
   end

   assign idx      = IDX_W'(rate_stage(rate));
   assign active   = run && (rate != 4'd0);
   assign tap_lvl  = active && cnt[idx];
   assign pf_pulse = active && tick && wrap[idx];

endmodule

// File: rtl/rtc_irq_merge.sv
module rtc_irq_merge #(
   parameter int NUM_SRC = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_req,
   input  logic [NUM_SRC-1:0] enable,
   input  logic               clr,
   output logic [NUM_SRC-1:0] flag_q,
   output logic               any_q
);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      // Set beats clear so an event on the clearing cycle is kept (R9)
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flag_q[i] <= 1'b0;
         else if (set_req[i]) flag_q[i] <= 1'b1;
         else if (clr)        flag_q[i] <= 1'b0;
      end
   end

   assign any_q = |(flag_q & enable);

endmodule

// File: rtl/rtc_rate_unit.sv
module rtc_rate_unit
   import rtc_rate_pkg::*;
#(
   parameter int DIV_W   = 14,
   parameter int NUM_EXT = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_32k,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_osc,
   input  logic [3:0]         cfg_rate,
   input  logic               cfg_sq_en,
   input  logic               cfg_raw_en,
   input  logic               cfg_pi_en,
   input  logic [NUM_EXT-1:0] cfg_src_en,
   input  logic [NUM_EXT-1:0] src_set,
   input  logic               flag_clr,
   output logic               sqw,
   output logic               irq_n,
   output logic               irq_any,
   output logic [NUM_EXT:0]   flags
);

   localparam int NUM_SRC = NUM_EXT + 1;

   if (DIV_W < 14) begin : g_bad_div
      $error("DIV_W must cover the slowest stage (>= 14)");
   end
   if (NUM_EXT < 1) begin : g_bad_ext
      $error("NUM_EXT must be at least 1");
   end

   logic [2:0]         osc_q;
   logic [3:0]         rate_q;
   logic               sq_en_q;
   logic               raw_en_q;
   logic               pie_q;
   logic [NUM_EXT-1:0] src_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osc_q    <= 3'b000;
         rate_q   <= 4'd0;
         sq_en_q  <= 1'b0;
         raw_en_q <= 1'b0;
         pie_q    <= 1'b0;
         src_en_q <= '0;
      end else if (cfg_we) begin
         osc_q    <= cfg_osc;
         rate_q   <= cfg_rate;
         sq_en_q  <= cfg_sq_en;
         raw_en_q <= cfg_raw_en;
         pie_q    <= cfg_pi_en;
         src_en_q <= cfg_src_en;
      end
   end

   osc_mode_e        mode;
   logic [DIV_W-1:0] cnt;
   logic             run;
   logic             tap_lvl;
   logic             pf_pulse;
   logic             any_q;

   assign mode = osc_decode(osc_q);

   rtc_divider #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_32k),
      .mode  (mode),
      .cnt   (cnt),
      .run   (run)
   );

   rtc_tap_sel #(.DIV_W(DIV_W)) u_tap (
      .cnt      (cnt),
      .tick     (tick_32k),
      .run      (run),
      .rate     (rate_q),
      .tap_lvl  (tap_lvl),
      .pf_pulse (pf_pulse)
   );

   rtc_irq_merge #(.NUM_SRC(NUM_SRC)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req ({src_set, pf_pulse}),
      .enable  ({src_en_q, pie_q}),
      .clr     (flag_clr),
      .flag_q  (flags),
      .any_q   (any_q)
   );

   // Raw override outranks enable and rate; nothing leaves a stopped chain
   assign sqw     = run && (raw_en_q ? tick_32k : (sq_en_q && tap_lvl));
   assign irq_any = any_q;
   assign irq_n   = ~any_q;

endmodule

// File: rtl/rtc_rate_chk.sv
module rtc_rate_chk #(
   parameter int NUM_EXT = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               run,
   input logic               pf_pulse,
   input logic [3:0]         rate_q,
   input logic               pie_q,
   input logic [NUM_EXT-1:0] src_set,
   input logic               flag_clr,
   input logic               sqw,
   input logic               irq_n,
   input logic [NUM_EXT:0]   flags
);

   AST_STOP_NO_PF: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !pf_pulse);                                              // R2
   AST_STOP_SQW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !sqw);                                                   // R2
   AST_PF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      pf_pulse |=> flags[0]);                                           // R7
   AST_PF_ENABLED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[0] && pie_q) |-> !irq_n);                                  // R8
   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !pf_pulse && (src_set == '0)) |=> (flags == '0));    // R9
   AST_RATE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_q == 4'd0) |-> !pf_pulse);                                  // R10

endmodule

bind rtc_rate_unit rtc_rate_chk #(.NUM_EXT(NUM_EXT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run),
   .pf_pulse (pf_pulse),
   .rate_q   (rate_q),
   .pie_q    (pie_q),
   .src_set  (src_set),
   .flag_clr (flag_clr),
   .sqw      (sqw),
   .irq_n    (irq_n),
   .flags    (flags)
);

// File: tb/test_rtc_rate_unit.sv
module test_rtc_rate_unit;

   localparam int NUM_EXT = 5;
   localparam int TICKDIV = 2;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               tick_32k = 1'b0;
   logic               cfg_we = 1'b0;
   logic [2:0]         cfg_osc = 3'b000;
   logic [3:0]         cfg_rate = 4'd0;
   logic               cfg_sq_en = 1'b0;
   logic               cfg_raw_en = 1'b0;
   logic               cfg_pi_en = 1'b0;
   logic [NUM_EXT-1:0] cfg_src_en = '0;
   logic [NUM_EXT-1:0] src_set = '0;
   logic               flag_clr = 1'b0;
   logic               sqw;
   logic               irq_n;
   logic               irq_any;
   logic [NUM_EXT:0]   flags;

   always #4 clk = ~clk;

   rtc_rate_unit #(.DIV_W(14), .NUM_EXT(NUM_EXT)) i_rtc_rate_unit (
      .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .cfg_we(cfg_we),
      .cfg_osc(cfg_osc), .cfg_rate(cfg_rate), .cfg_sq_en(cfg_sq_en),
      .cfg_raw_en(cfg_raw_en), .cfg_pi_en(cfg_pi_en), .cfg_src_en(cfg_src_en),
      .src_set(src_set), .flag_clr(flag_clr), .sqw(sqw), .irq_n(irq_n),
      .irq_any(irq_any), .flags(flags)
   );

   typedef struct { int code; int half; int full; } item_t;
   item_t q[$];

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Expected stage per rate code, from the requirement table (R3)
   function automatic int stage_of(input int code);
      case (code)
         1: return 6;
         2: return 7;
         3: return 1;
         4: return 2;
         default: return code - 2;
      endcase
   endfunction

   // Tick generator and scoreboard monitor, both 1 time unit after negedge
   int  tdiv = 0;
   int  tcnt = 0;
   int  rise_at = -1;
   int  mstate = 0;
   bit  arm = 0;
   bit  prev_sqw = 0;
   bit  prev_pf = 0;

   always @(negedge clk) begin
      #1;
      if (mstate == 2 && tick_32k) tcnt++;
      if (mstate == 1) mstate = 2;
      if (arm) begin
         arm = 0; mstate = 1; tcnt = 0; rise_at = -1; prev_sqw = 0;
      end else if (mstate == 2) begin
         if (sqw && !prev_sqw && rise_at < 0) rise_at = tcnt;
         prev_sqw = sqw;
         if (flags[0] && !prev_pf) begin
            item_t it;
            if (q.size() == 0) begin
               chk(0, "R3 unexpected flag", tcnt, 0);
            end else begin
               it = q.pop_front();
               chk(tcnt == it.full, $sformatf("R3 code %0d flag tick", it.code), tcnt, it.full);
               chk(rise_at == it.half, $sformatf("R4 code %0d sqw rise tick", it.code), rise_at, it.half);
            end
            mstate = 0;
         end
      end
      prev_pf = flags[0];
      tdiv++;
      tick_32k = (tdiv % TICKDIV == 0);
   end

   task automatic write_cfg(input logic [2:0] osc, input logic [3:0] rate, input bit sq,
                            input bit raw, input bit pie, input logic [NUM_EXT-1:0] en);
      @(negedge clk);
      cfg_osc = osc; cfg_rate = rate; cfg_sq_en = sq; cfg_raw_en = raw;
      cfg_pi_en = pie; cfg_src_en = en; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic clear_flags();
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
   endtask

   // Driver: restart chain, push expectation, wait for monitor to consume
   task automatic drive_rate(input int code);
      item_t it;
      int k;
      k = stage_of(code);
      @(negedge clk);
      flag_clr = 1'b1; cfg_we = 1'b1; cfg_osc = 3'b110;
      cfg_rate = 4'(code); cfg_sq_en = 1'b1; cfg_raw_en = 1'b0; cfg_pi_en = 1'b0;
      @(negedge clk);
      flag_clr = 1'b0;
      cfg_osc = code[0] ? 3'b011 : 3'b010;   // R1: bit 0 alternates
      it.code = code; it.half = 1 << k; it.full = 1 << (k + 1);
      q.push_back(it);
      arm = 1;
      @(negedge clk);
      cfg_we = 1'b0;
      while (q.size() != 0) @(negedge clk);
   endtask

   task automatic wait_ticks(input int n);
      repeat (n * TICKDIV) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #3;
      chk(flags == '0, "R8 reset flags", int'(flags), 0);
      chk(irq_n == 1'b1, "R8 reset irq_n", int'(irq_n), 1);
      chk(sqw == 1'b0, "R2 reset sqw (osc stopped)", int'(sqw), 0);
      rst_n = 1'b1;

      // R3/R4/R1: every non-zero rate code
      for (int c = 1; c <= 15; c++) drive_rate(c);

      // R2: stopped codes, raw override on, fast rate
      for (int oc = 0; oc < 8; oc++) begin
         if (oc[2:1] == 2'b01) continue;
         clear_flags();
         write_cfg(3'(oc), 4'd3, 1'b1, 1'b1, 1'b1, '0);
         wait_ticks(20);
         #3;
         chk(flags[0] == 1'b0, $sformatf("R2 osc %0d periodic flag", oc), int'(flags[0]), 0);
         begin
            bit seen = 0;
            for (int i = 0; i < 8; i++) begin @(negedge clk); #3; if (sqw) seen = 1; end
            chk(!seen, $sformatf("R2 osc %0d sqw low", oc), int'(seen), 0);
         end
      end

      // R5: raw override follows tick with sq_en off and rate 0
      write_cfg(3'b010, 4'd0, 1'b0, 1'b1, 1'b0, '0);
      begin
         int mism = 0;
         for (int i = 0; i < 16; i++) begin @(negedge clk); #3; if (sqw !== tick_32k) mism++; end
         chk(mism == 0, "R5 raw override tracks tick", mism, 0);
      end

      // R6: sq_en off, override off, fast rate running
      clear_flags();
      write_cfg(3'b010, 4'd3, 1'b0, 1'b0, 1'b0, '0);
      begin
         bit seen = 0;
         for (int i = 0; i < 40; i++) begin @(negedge clk); #3; if (sqw) seen = 1; end
         chk(!seen, "R6 sqw low when disabled", int'(seen), 0);
      end
      // R7: flag set without PIE, no interrupt
      #1;
      chk(flags[0] == 1'b1, "R7 periodic flag without enable", int'(flags[0]), 1);
      chk(irq_n == 1'b1 && irq_any == 1'b0, "R7 no irq without enable", int'(irq_n), 1);
      write_cfg(3'b010, 4'd3, 1'b0, 1'b0, 1'b1, '0);
      #3;
      chk(irq_n == 1'b0 && irq_any == 1'b1, "R7 irq once enabled", int'(irq_n), 0);

      // R10: rate zero, sq_en on: no flag and sqw low
      write_cfg(3'b010, 4'd0, 1'b1, 1'b0, 1'b1, '0);
      clear_flags();
      begin
         bit seen = 0;
         for (int i = 0; i < 80; i++) begin @(negedge clk); #3; if (sqw) seen = 1; end
         chk(!seen, "R10 sqw low at rate 0", int'(seen), 0);
      end
      chk(flags[0] == 1'b0, "R10 no flag at rate 0", int'(flags[0]), 0);

      // R8: external flags with and without enable
      write_cfg(3'b000, 4'd0, 1'b0, 1'b0, 1'b0, 5'b00100);
      @(negedge clk); src_set = 5'b00001;
      @(negedge clk); src_set = '0; #3;
      chk(flags[1] == 1'b1, "R8 ext flag 1 set", int'(flags[1]), 1);
      chk(irq_any == 1'b0 && irq_n == 1'b1, "R8 disabled flag no irq", int'(irq_any), 0);
      @(negedge clk); src_set = 5'b00100;
      @(negedge clk); src_set = '0; #3;
      chk(irq_any == 1'b1 && irq_n == 1'b0, "R8 enabled flag drives irq", int'(irq_any), 1);

      // R9: clear with coincident set on another source
      @(negedge clk); flag_clr = 1'b1; src_set = 5'b00010;
      @(negedge clk); flag_clr = 1'b0; src_set = '0; #3;
      chk(flags == 6'b000100, "R9 clear keeps coincident set", int'(flags), 4);
      chk(irq_any == 1'b0, "R9 irq drops after clear", int'(irq_any), 0);

      // R2: restart from held state resumes at zero (rate 3, stage 1)
      clear_flags();
      write_cfg(3'b110, 4'd3, 1'b1, 1'b0, 1'b0, '0);
      wait_ticks(10);
      #3;
      chk(flags[0] == 1'b0 && sqw == 1'b0, "R2 held chain quiet", int'(flags[0]), 0);
      drive_rate(3);

      done = 1;
   end

   initial begin
      fork
         begin
            repeat (190000) @(posedge clk);
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired, expected completion");
         end
         wait (done);
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule